// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an external Ethernet PHY through a small memory-mapped register window. The host first writes the target PHY and register numbers into an address register. For a write it also loads a 16-bit data value. It then sets a request bit in the control register. The controller builds a clause-22 management frame, shifts it out on MDIO under a divided management clock, and on reads collects the 16 bits the PHY returns.

The host polls a busy flag in the status register. Once the flag drops, a read's result is in the read-data register. The management clock runs only while a frame is on the wire and rests low otherwise. The host bus is a single-cycle word-indexed write strobe with a combinational read port.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status word is 0, MDC is low, MDIO is not driven (mdio_oe=0) and the read-data word is 0.
- R2: Register index 0 is the address word, holding the PHY number in bits [12:8] and the register number in bits [4:0]. Reads return only those bits. Both numbers are sent most significant bit first in the frame.
- R3: Index 2 is the control word. A write with bit 3 set requests a read and a write with bit 2 set requests a write. When both bits are set, a write is performed. The read opcode is 10 and the write opcode is 01.
- R4: Index 3 is the status word. Its bit 0 is 1 from the cycle after the accepted request, for exactly 64 MDC periods, and then returns to 0.
- R5: While busy, MDC has period DIV system clocks. It is low for the first DIV/2 clocks of each bit and high for the rest. While idle it is held low.
- R6: The frame is 32 ones, then 01, the opcode, 5 PHY bits, 5 register bits, a 2-bit turnaround and 16 data bits. Bits change only when MDC falls, so MDIO stays stable while MDC is high.
- R7: On a read, MDIO is released during the turnaround and data bits. Each data bit is sampled when MDC rises. Index 4 then returns the result in bits [15:0], and bits [31:16] read as zero.
- R8: Index 1 holds the 16-bit write data. A write request captures it, so changing it during the transaction does not alter the frame. On a write the turnaround is driven as 10.
- R9: The control word always reads back 0. A request made while busy is ignored, and a control write with neither request bit set starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A behavioural model predicts MDC, MDIO output, output enable and the busy flag on every clock. The bench exercises four patterns:

- A plain write with a mixed-bit data word and distinct PHY and register numbers. This separates field order and bit order errors.
- Reads returning a mixed value, all ones and a single low bit. These separate sampling-phase and shift-direction errors, and show whether the upper read bits stay clear.
- A control write with both request bits set. This checks the opcode priority and that the read-data word is untouched.
- Writes to the control and write-data registers in the middle of a frame. These must leave the frame unchanged and must not start a second transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  localparam logic [2:0] IDX_ADDR   = 3'd0;
  localparam logic [2:0] IDX_WDATA  = 3'd1;
  localparam logic [2:0] IDX_CTRL   = 3'd2;
  localparam logic [2:0] IDX_STATUS = 3'd3;
  localparam logic [2:0] IDX_RDATA  = 3'd4;

  localparam int CTRL_WR_BIT = 2;
  localparam int CTRL_RD_BIT = 3;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  assign rise_tick = en && (cnt_q == CW'(HALF - 1));
  assign fall_tick = en && (cnt_q == CW'(DIV - 1));
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (fall_tick) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (rise_tick) mdc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_op_e    op,
  input  logic [4:0]  phy,
  input  logic [4:0]  regn,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  busy_q, busy_d;
  logic                  is_rd_q, is_rd_d;
  logic [15:0]           sh_q, sh_d;
  logic [1:0]            ta_bits;
  logic [15:0]           data_bits;

  assign ta_bits   = (op == OP_WRITE) ? 2'b10 : 2'b11;
  assign data_bits = (op == OP_WRITE) ? wdata : 16'h0000;
  assign done      = busy_q && fall_tick && (idx_q == IW'(FRAME_BITS - 1));

  always_comb begin
    frame_d = frame_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    is_rd_d = is_rd_q;
    sh_d    = sh_q;
    if (!busy_q) begin
      if (start) begin
        frame_d = {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta_bits, data_bits};
        idx_d   = '0;
        busy_d  = 1'b1;
        is_rd_d = (op == OP_READ);
      end
    end else begin
      if (rise_tick && is_rd_q && (idx_q >= IW'(DATA_BIT)))
        sh_d = {sh_q[14:0], mdio_i};
      if (fall_tick) begin
        if (done) begin
          busy_d = 1'b0;
        end else begin
          frame_d = {frame_q[FRAME_BITS-2:0], 1'b1};
          idx_d   = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      sh_q    <= '0;
    end else begin
      frame_q <= frame_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      is_rd_q <= is_rd_d;
      sh_q    <= sh_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = busy_q ? frame_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && (!is_rd_q || (idx_q < IW'(TA_BIT)));
  assign rd_data = sh_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [4:0]  phy_q, phy_d;
  logic [4:0]  regn_q, regn_d;
  logic [15:0] wdat_q, wdat_d;
  logic [15:0] rdat_q, rdat_d;
  logic        busy, done, start, rise_tick, fall_tick, rd_op;
  logic [15:0] shift_data;
  mdio_op_e    op;

  assign start = reg_wr && (reg_addr == IDX_CTRL) && !busy &&
                 (reg_wdata[CTRL_WR_BIT] || reg_wdata[CTRL_RD_BIT]);
  assign op    = reg_wdata[CTRL_WR_BIT] ? OP_WRITE : OP_READ;

  always_comb begin
    phy_d  = phy_q;
    regn_d = regn_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    if (reg_wr && (reg_addr == IDX_ADDR)) begin
      phy_d  = reg_wdata[12:8];
      regn_d = reg_wdata[4:0];
    end
    if (reg_wr && (reg_addr == IDX_WDATA)) wdat_d = reg_wdata[15:0];
    if (done && rd_op) rdat_d = shift_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= '0;
      regn_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      rd_op  <= 1'b0;
    end else begin
      phy_q  <= phy_d;
      regn_q <= regn_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
      if (start) rd_op <= (op == OP_READ);
    end
  end

  always_comb begin
    unique case (reg_addr)
      IDX_ADDR:   reg_rdata = {19'b0, phy_q, 3'b0, regn_q};
      IDX_WDATA:  reg_rdata = {16'b0, wdat_q};
      IDX_STATUS: reg_rdata = {31'b0, busy};
      IDX_RDATA:  reg_rdata = {16'b0, rdat_q};
      default:    reg_rdata = 32'b0;
    endcase
  end

  mdio_clkdiv #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .phy       (phy_q),
    .regn      (regn_q),
    .wdata     (wdat_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (shift_data)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R5
  AST_OE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R1
  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R6
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == IDX_RDATA) |-> (reg_rdata[31:16] == 16'h0000)); // R7
  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == IDX_CTRL && (reg_wdata[3] || reg_wdata[2])) |=> busy); // R4
  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == IDX_CTRL) |-> (reg_rdata == 32'h0)); // R9
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
  localparam int DIV = 8;
  localparam int HALF = DIV / 2;
  localparam int NBITS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd3;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl #(.DIV(DIV)) u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd3;
  endtask

  // Reference frame: queue of bits, first sent first.
  function automatic void build_frame(ref bit q[$], input bit is_wr, input bit [4:0] p,
                                      input bit [4:0] r, input bit [15:0] d);
    q.delete();
    for (int i = 0; i < 32; i++) q.push_back(1'b1);
    q.push_back(1'b0); q.push_back(1'b1);
    if (is_wr) begin q.push_back(1'b0); q.push_back(1'b1); end
    else       begin q.push_back(1'b1); q.push_back(1'b0); end
    for (int i = 4; i >= 0; i--) q.push_back(p[i]);
    for (int i = 4; i >= 0; i--) q.push_back(r[i]);
    q.push_back(1'b1); q.push_back(1'b0);
    for (int i = 15; i >= 0; i--) q.push_back(is_wr ? d[i] : 1'b0);
  endfunction

  // Runs one transaction from the request and compares every clock. R3 R4 R5 R6 R7 R8 R9
  task automatic run_txn(input bit [3:2] req, input bit [4:0] p, input bit [4:0] r,
                         input bit [15:0] wd, input bit [15:0] phy_val, input bit disturb);
    bit q[$];
    bit is_wr;
    int bad_o, bad_oe, bad_mdc, bad_busy;
    is_wr = req[2];
    build_frame(q, is_wr, p, r, wd);
    bad_o = 0; bad_oe = 0; bad_mdc = 0; bad_busy = 0;
    host_write(3'd0, {19'b0, p, 3'b0, r});
    host_write(3'd1, {16'hDEAD, wd});
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = {28'b0, req, 2'b00};
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    for (int k = 0; k <= NBITS * DIV; k++) begin
      int b; int c; bit bsy; bit e_mdc; bit e_oe;
      b = k / DIV; c = k % DIV; bsy = (k < NBITS * DIV);
      e_mdc = bsy && (c >= HALF);
      e_oe  = bsy && (is_wr || b < 46);
      reg_addr = (k == 1) ? 3'd2 : 3'd3;
      if (disturb && k == 100) begin
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h8;
      end else if (disturb && k == 200) begin
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0000_5A5A;
      end else reg_wr = 1'b0;
      mdio_i = (!is_wr && bsy && b >= 48) ? phy_val[15 - (b - 48)] : 1'b1;
      #1;
      if (k == 1) chk("R9 control word reads zero", reg_rdata, 32'h0);
      if (reg_addr == 3'd3 && reg_rdata !== {31'b0, bsy}) bad_busy++;
      if (mdc !== e_mdc) bad_mdc++;
      if (mdio_oe !== e_oe) bad_oe++;
      if (e_oe && bsy && mdio_o !== q[b]) bad_o++;
      @(posedge clk); @(negedge clk);
    end
    reg_wr = 1'b0; reg_addr = 3'd3;
    chk("R4 status busy per cycle", bad_busy, 0);
    chk("R5 mdc waveform per cycle", bad_mdc, 0);
    chk(is_wr ? "R8 write drives every bit" : "R7 read release timing", bad_oe, 0);
    chk(disturb ? "R8 R9 frame unchanged by mid-frame writes" : "R2 R3 R6 frame bits", bad_o, 0);
    #1;
    chk("R4 idle after frame", reg_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 status after reset", reg_rdata, 32'h0);
    chk("R1 mdc after reset", {31'b0, mdc}, 32'h0);
    chk("R1 oe after reset", {31'b0, mdio_oe}, 32'h0);
    reg_addr = 3'd4; #1;
    chk("R1 read data after reset", reg_rdata, 32'h0);
    reg_addr = 3'd3;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 address readback masks unused bits
    host_write(3'd0, 32'hFFFF_FFFF);
    reg_addr = 3'd0; #1;
    chk("R2 address readback", reg_rdata, 32'h0000_1F1F);
    reg_addr = 3'd3;

    // R9 control write without request bits starts nothing
    host_write(3'd2, 32'hFFFF_FFF3);
    #1;
    chk("R9 no request no busy", reg_rdata, 32'h0);
    chk("R9 no request mdio idle", {31'b0, mdio_oe}, 32'h0);

    // write with mid-frame disturbance, R8 and R9
    run_txn(2'b01, 5'h11, 5'h1A, 16'hA5C3, 16'h0000, 1'b1);
    reg_addr = 3'd4; #1;
    chk("R8 write leaves read data", reg_rdata, 32'h0);

    // R7 read with mixed value
    run_txn(2'b10, 5'h03, 5'h02, 16'h0000, 16'h8E71, 1'b0);
    reg_addr = 3'd4; #1;
    chk("R7 read result", reg_rdata, 32'h0000_8E71);

    // R3 both request bits: write wins, read data untouched
    run_txn(2'b11, 5'h1F, 5'h00, 16'h0001, 16'h0000, 1'b0);
    reg_addr = 3'd4; #1;
    chk("R3 both bits keep read data", reg_rdata, 32'h0000_8E71);

    // R7 reads of all ones and single low bit
    run_txn(2'b10, 5'h00, 5'h1F, 16'h0000, 16'hFFFF, 1'b0);
    reg_addr = 3'd4; #1;
    chk("R7 read all ones", reg_rdata, 32'h0000_FFFF);
    run_txn(2'b10, 5'h15, 5'h0A, 16'h0000, 16'hFFFE, 1'b0);
    reg_addr = 3'd4; #1;
    chk("R7 read low lsb", reg_rdata, 32'h0000_FFFE);

    finish_run();
  end
endmodule